// File: doc/BRIEF.md
# Four-Slot ADC Conversion Sequencer

This block controls an external 8-bit successive-approximation converter. The converter samples one of eight analog inputs. Software writes a control register, and the block then runs a sequence of four conversions. Each result lands in one of four read-only result slots. In single-channel mode, one chosen input is converted four times in a row. In group mode, each of four adjacent inputs is converted once. A sequence runs once or repeats without end.

The block drives a channel-select output to the analog multiplexer. Each conversion is one handshake with the converter core: a one-cycle start pulse, a wait for done, then the data is latched. A completion flag rises after the fourth result of a sequence is stored, and any control write clears it. A converter-enable bit sits in a separate options register. While that bit is low, no conversion is started, and a pending sequence waits until the bit is set again.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every readable register returns 0 and `conv_start_o` is low. The control register is at address 0, result slots 1..4 are at addresses 1..4, and the options register is at address 7.
- R2: The completion flag (control bit 7) becomes 1 in the cycle after the fourth result of a sequence is stored. Any write to address 0 clears it.
- R3: The control register reads as follows: bit 7 is the completion flag, bit 6 is always 0, bit 5 is the repeat flag, bit 4 is the group flag, and bits 3..0 are the select field. A 1 written to bit 6 is ignored.
- R4: With the repeat flag at 0, a control write starts exactly four conversions, after which no further start pulse occurs.
- R5: With the repeat flag at 1, sequences follow one another without end and overwrite slots 1..4 in order. The completion flag stays 1 from the end of the first sequence until the next control write.
- R6: With the group flag at 0, all four conversions use channel select bits 2..0 of the control register.
- R7: With the group flag at 1, conversion k (k = 0..3) uses channel {select bit 2, k}, so select bit 2 picks inputs 0..3 or 4..7. Select bits 1..0 have no effect.
- R8: Bit 7 of the options register enables the converter. While it is 0, no start pulse is issued. A waiting sequence resumes once the bit is set again. The other options bits read as 0.
- R9: Each conversion drives `conv_start_o` high for one cycle. The channel select is held until done arrives. The data present when done is seen is stored in the current slot, in slot order 1, 2, 3, 4.
- R10: A control write during a sequence abandons that sequence. A new sequence then starts from slot 1 with the new settings, and a done seen in the same cycle as the write is discarded.
- R11: Writes to addresses 1..4 leave the results unchanged, and unmapped addresses (5, 6) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| conv_chan_o | output | 3 | Channel select to the analog multiplexer |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | 8 | Converter result |

## Verification
The embedded assertions check these properties on every cycle:
- the start pulse lasts a single cycle, and no start occurs while the converter is disabled;
- the channel select is held after a start;
- the completion flag is set and cleared on the right cycles;
- result slots change only when a result is stored;
- a one-shot sequence falls idle after its last result.

Some behaviours can only be shown by the bench's scenarios, compared against the behavioural model every clock:
- the channel order across a group;
- that select bits 1..0 are ignored in group mode;
- restart from slot 1 after an abort;
- resumption after the enable is restored;
- the mapping of converter data into the four slots.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  // control fields below the completion flag, bit 5 down to bit 0
  typedef struct packed {
    logic       scan;
    logic       mult;
    logic [3:0] sel;
  } ctrl_t;

endpackage

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int SLOT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              en_i,
  input  logic              scan_i,
  input  logic              conv_done_i,
  output logic              start_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              store_o,
  output logic              seq_end_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      slot_q  <= '0;
    end else if (restart_i) begin
      state_q <= SEQ_START;
      slot_q  <= '0;
    end else begin
      case (state_q)
        SEQ_START: if (en_i) state_q <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (conv_done_i) begin
            if (slot_q == LAST_SLOT) begin
              slot_q  <= '0;
              state_q <= scan_i ? SEQ_START : SEQ_IDLE;
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= SEQ_START;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign start_o   = (state_q == SEQ_START) && en_i;
  assign slot_o    = slot_q;
  assign store_o   = (state_q == SEQ_WAIT) && conv_done_i && !restart_i;
  assign seq_end_o = store_o && (slot_q == LAST_SLOT);

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && !restart_i |=> !start_o); // R9

  AST_NO_START_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !start_o); // R8

  AST_RESTART_SLOT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (slot_o == '0) && !store_o); // R10

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_end_o && !scan_i && !restart_i |=> !start_o && !store_o); // R4

endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan #(
  parameter int CH_W   = 3,
  parameter int SLOT_W = 2
) (
  input  logic              mult_i,
  input  logic [CH_W-1:0]   sel_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [CH_W-1:0]   chan_o
);

  localparam int GRP_W = CH_W - SLOT_W;

  generate
    if (GRP_W > 0) begin : g_grouped
      // upper select bits choose the group, slot counter walks inside it
      assign chan_o = mult_i ? {sel_i[CH_W-1:SLOT_W], slot_i} : sel_i;
    end else begin : g_flat
      assign chan_o = mult_i ? slot_i[CH_W-1:0] : sel_i;
    end
  endgenerate

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int N_SLOTS  = 4,
  parameter int ADDR_W   = 3,
  parameter int OPT_ADDR = 7,
  parameter int SLOT_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              store_i,
  input  logic [SLOT_W-1:0] store_slot_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic              seq_end_i,
  output ctrl_t             ctrl_o,
  output logic              en_o,
  output logic              ctrl_wr_o
);

  localparam logic [ADDR_W-1:0] CTRL_A = '0;
  localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_ADDR);

  ctrl_t                          ctrl_q;
  logic                           ccf_q;
  logic                           en_q;
  logic [N_SLOTS-1:0][DATA_W-1:0] res_q;
  logic                           opt_wr;
  logic                           unused_wdata;

  assign ctrl_wr_o    = wr_i && (addr_i == CTRL_A);
  assign opt_wr       = wr_i && (addr_i == OPT_A);
  assign unused_wdata = ^wdata_i[DATA_W-2:6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ccf_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (ctrl_wr_o) ctrl_q <= ctrl_t'(wdata_i[5:0]);
      if (ctrl_wr_o)      ccf_q <= 1'b0;
      else if (seq_end_i) ccf_q <= 1'b1;
      if (opt_wr) en_q <= wdata_i[DATA_W-1];
    end
  end

  generate
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                      res_q[g] <= '0;
        else if (store_i && store_slot_i == SLOT_W'(g))   res_q[g] <= store_data_i;
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) rdata_o = DATA_W'({ccf_q, 1'b0, ctrl_q});
    if (addr_i == OPT_A)  rdata_o = {en_q, {(DATA_W-1){1'b0}}};
    for (int k = 0; k < N_SLOTS; k++)
      if (addr_i == ADDR_W'(k + 1)) rdata_o = res_q[k];
  end

  assign ctrl_o = ctrl_q;
  assign en_o   = en_q;

  AST_CCF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |=> !ccf_q); // R2

  AST_CCF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_end_i && !ctrl_wr_o |=> ccf_q); // R2

  AST_CCF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccf_q && !ctrl_wr_o |=> ccf_q); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |=> $stable(res_q)); // R11

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int N_SLOTS  = 4,
  parameter int CH_W     = 3,
  parameter int ADDR_W   = 3,
  parameter int OPT_ADDR = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [CH_W-1:0]   conv_chan_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i
);

  localparam int SLOT_W = $clog2(N_SLOTS);

  ctrl_t             ctrl;
  logic              en;
  logic              ctrl_wr;
  logic              store;
  logic              seq_end;
  logic [SLOT_W-1:0] slot;
  logic              unused_sel;

  assign unused_sel = ^ctrl.sel;

  adc_seq_regs #(
    .DATA_W(DATA_W), .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W),
    .OPT_ADDR(OPT_ADDR), .SLOT_W(SLOT_W)
  ) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (bus_wr_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .rdata_o      (bus_rdata_o),
    .store_i      (store),
    .store_slot_i (slot),
    .store_data_i (conv_data_i),
    .seq_end_i    (seq_end),
    .ctrl_o       (ctrl),
    .en_o         (en),
    .ctrl_wr_o    (ctrl_wr)
  );

  adc_seq_engine #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) i_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (ctrl_wr),
    .en_i        (en),
    .scan_i      (ctrl.scan),
    .conv_done_i (conv_done_i),
    .start_o     (conv_start_o),
    .slot_o      (slot),
    .store_o     (store),
    .seq_end_o   (seq_end)
  );

  adc_seq_chan #(.CH_W(CH_W), .SLOT_W(SLOT_W)) i_chan (
    .mult_i (ctrl.mult),
    .sel_i  (ctrl.sel[CH_W-1:0]),
    .slot_i (slot),
    .chan_o (conv_chan_o)
  );

  AST_CHAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o && !ctrl_wr |=> $stable(conv_chan_o)); // R9

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic       hold = 1'b0;
  logic [2:0] wr_addr = '0, hold_addr = '0, rot_addr = '0;
  logic [7:0] wdata = '0;
  logic [2:0] bus_addr;
  logic [7:0] rdata;
  logic [2:0] chan;
  logic       start;
  logic       done = 1'b0;
  logic [7:0] cdata = '0;

  always #10 clk = ~clk;

  assign bus_addr = wr ? wr_addr : (hold ? hold_addr : rot_addr);

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .conv_chan_o(chan),
    .conv_start_o(start), .conv_done_i(done), .conv_data_i(cdata)
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 start pending, 2 awaiting done
  int         m_phase = 0;
  logic [1:0] m_slot = '0;
  bit         m_ccf = 0, m_scan = 0, m_mult = 0, m_en = 0;
  logic [3:0] m_sel = '0;
  logic [7:0] m_res [4] = '{default: 8'h00};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_slot = '0; m_ccf = 0; m_scan = 0; m_mult = 0; m_en = 0; m_sel = '0;
      for (int i = 0; i < 4; i++) m_res[i] = '0;
    end else begin
      if (wr && wr_addr == 3'd0) begin
        m_ccf = 0; m_scan = wdata[5]; m_mult = wdata[4]; m_sel = wdata[3:0];
        m_phase = 1; m_slot = '0;
      end else if (m_phase == 1 && m_en) begin
        m_phase = 2;
      end else if (m_phase == 2 && done) begin
        m_res[m_slot] = cdata;
        if (m_slot == 2'd3) begin
          m_ccf = 1; m_slot = '0; m_phase = m_scan ? 1 : 0;
        end else begin
          m_slot = m_slot + 2'd1; m_phase = 1;
        end
      end
      if (wr && wr_addr == 3'd7) m_en = wdata[7];
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0:                      return {m_ccf, 1'b0, m_scan, m_mult, m_sel};
      3'd1, 3'd2, 3'd3, 3'd4:    return m_res[a - 3'd1];
      3'd7:                      return {m_en, 7'b0};
      default:                   return 8'h00;
    endcase
  endfunction

  // converter model with programmable latency; a new start supersedes the old one
  int         lat = 3, cnt = 0, nconv = 0, nstart = 0;
  logic [2:0] cchan = '0;

  always @(negedge clk) begin
    rot_addr <= rot_addr + 3'd1;
    if (done) done = 1'b0;
    if (!rst_n) begin
      cnt = 0;
    end else if (start) begin
      cnt = lat; cchan = chan; nstart++;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        done = 1'b1; cdata = {cchan, nconv[4:0]}; nconv++;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit es;
      logic [2:0] ec;
      logic [7:0] er;
      string t;
      es = (m_phase == 1) && m_en;
      chk(start == es, m_en ? "R9 start pulse" : "R8 start while disabled", start, es);
      if (es) begin
        ec = m_mult ? {m_sel[2], m_slot} : m_sel[2:0];
        chk(chan == ec, m_mult ? "R7 group channel" : "R6 single channel", chan, ec);
      end
      er = exp_rd(bus_addr);
      t = (bus_addr == 3'd0) ? "R3 control read" :
          (bus_addr == 3'd7) ? "R8 options read" : "R11 result read";
      chk(rdata == er, t, rdata, er);
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    wr_addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    hold_addr = a; hold = 1'b1;
    #3 v = rdata;
    @(negedge clk);
    hold = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v, r;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(3'd0, v); chk(v == 8'h00, "R1 control after reset", v, 8'h00);
    rd_reg(3'd1, v); chk(v == 8'h00, "R1 slot1 after reset", v, 8'h00);
    rd_reg(3'd4, v); chk(v == 8'h00, "R1 slot4 after reset", v, 8'h00);
    rd_reg(3'd7, v); chk(v == 8'h00, "R1 options after reset", v, 8'h00);
    chk(start == 1'b0, "R1 no start after reset", start, 0);

    // R8 disabled: control write waits
    wr_reg(3'd0, 8'h07);
    idle(10);
    chk(nstart == 0, "R8 no start while disabled", nstart, 0);
    wr_reg(3'd7, 8'h80);
    idle(40);
    chk(nstart == 4, "R4 one pass of four", nstart, 4);
    rd_reg(3'd0, v); chk(v == 8'h87, "R2 flag set after pass", v, 8'h87);
    rd_reg(3'd1, v); chk(v == 8'hE0, "R6 R9 slot1 channel 7 first result", v, 8'hE0);
    rd_reg(3'd4, v); chk(v == 8'hE3, "R6 R9 slot4 channel 7 fourth result", v, 8'hE3);
    idle(20);
    chk(nstart == 4, "R4 idle after pass", nstart, 4);

    // R5 R7 continuous group, upper group, low select bits set but ignored
    n0 = nstart;
    wr_reg(3'd0, 8'h36);
    rd_reg(3'd0, v); chk(v[7] == 1'b0, "R2 flag cleared by write", v[7], 0);
    idle(80);
    chk(nstart - n0 > 4, "R5 sequences repeat", nstart - n0, 5);
    rd_reg(3'd0, v); chk(v == 8'hB6, "R5 flag stays set", v, 8'hB6);
    for (int k = 0; k < 4; k++) begin
      rd_reg(3'(k + 1), v);
      chk(v[7:5] == 3'(4 + k), "R7 upper group slot channel", v[7:5], 4 + k);
    end

    // R10 abort mid-sequence
    wr_reg(3'd0, 8'h20);
    idle(7);
    n0 = nstart;
    wr_reg(3'd0, 8'h05);
    idle(40);
    chk(nstart - n0 == 4, "R10 restart gives four conversions", nstart - n0, 4);
    for (int k = 0; k < 4; k++) begin
      rd_reg(3'(k + 1), v);
      chk(v[7:5] == 3'd5, "R10 new channel in every slot", v[7:5], 5);
    end

    // R8 pause and resume with a slower converter
    lat = 5;
    wr_reg(3'd0, 8'h20);
    idle(8);
    wr_reg(3'd7, 8'h00);
    idle(10);
    n0 = nstart;
    idle(20);
    chk(nstart == n0, "R8 paused while disabled", nstart, n0);
    rd_reg(3'd7, v); chk(v == 8'h00, "R8 options cleared", v, 8'h00);
    wr_reg(3'd7, 8'hFF);
    rd_reg(3'd7, v); chk(v == 8'h80, "R8 only enable bit reads back", v, 8'h80);
    idle(20);
    chk(nstart > n0, "R8 resumes after enable", nstart, n0 + 1);

    // R3 R11 ignored writes and unmapped reads
    wr_reg(3'd0, 8'h4D);
    idle(50);
    rd_reg(3'd2, r);
    wr_reg(3'd2, ~r);
    rd_reg(3'd2, v); chk(v == r, "R11 result write ignored", v, r);
    rd_reg(3'd0, v); chk(v == 8'h8D, "R3 bit6 ignored", v, 8'h8D);
    rd_reg(3'd5, v); chk(v == 8'h00, "R11 unmapped address 5", v, 8'h00);
    rd_reg(3'd6, v); chk(v == 8'h00, "R11 unmapped address 6", v, 8'h00);

    idle(5);
    finish_run();
  end

endmodule